// File: doc/BRIEF.md
# Video mixer interrupt status register

This block gathers the interrupt events of a video layer mixer and holds them as sticky flags. It watches four event sources. The first is the vertical-sync event. The other three are underflow events that come from the line-buffer controllers of the video plane, graphic layer 1 and graphic layer 0. Software reads and clears the flags over a simple synchronous 32-bit register port, which has a byte address, a write enable, a read enable, write data and registered read data.

The clear rules differ between the sources. Software clears an underflow flag by writing a 1 to that flag's own bit position. The vsync flag is read-only at its bit position; software clears it through a separate write-only bit. A second register holds one enable bit per source. The interrupt output is asserted while any enabled flag is set. Software should clear the vsync flag before it enables that source, so that an old event does not raise the interrupt at once. A pure vertical-sync interrupt is the case where the vsync flag is set and all three underflow flags are clear; software tells this case apart by reading the status word.

Top module: `mixirq_status_top`

## Requirements
- R1: After reset, all four flags and all four enable bits are 0, `irq_out` is 0, and `bus_rdata` is 0.
- R2: A one-cycle event pulse sets its flag on the next clock edge, and the flag stays set until it is cleared. In the status word at offset 0x0C, bit 0 is vsync, bit 8 is graphic layer 0, bit 9 is graphic layer 1 and bit 10 is the video plane.
- R3: A write to 0x0C clears each underflow flag whose bit (10, 9 or 8) is 1 in the write data. Flags whose bit is 0 are left unchanged.
- R4: The vsync flag is read-only at bit 0. A write to 0x0C with bit 11 equal to 0 leaves the vsync flag unchanged, whatever bit 0 holds.
- R5: A write to 0x0C with bit 11 equal to 1 clears the vsync flag. Bit 11 always reads as 0.
- R6: Status bits 31:12 and 7:1 always read as 0. Writes to these bits have no effect on any flag.
- R7: When an event pulse and a software clear hit the same flag in the same cycle, the flag ends up set.
- R8: The enable register sits at offset 0x10 and uses the same bit positions as the status word: bit 0 vsync, bit 8 graphic layer 0, bit 9 graphic layer 1, bit 10 video plane. These four bits can be written and read back. Every other bit of the enable register reads as 0.
- R9: `irq_out` is 1 exactly when at least one flag is set and its enable bit is also set. It follows the flag and enable registers with no further delay. If the vsync flag is cleared before vsync is enabled, enabling vsync does not raise `irq_out`.
- R10: A read of any offset other than 0x0C and 0x10 returns 0. A write to any other offset changes no flag and no enable bit.
- R11: Read data is registered. It appears on `bus_rdata` in the cycle after the read request, and it is the value the register held before any write made in the same cycle. In a cycle with no read request, `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write request for this cycle |
| bus_re | input | 1 | Read request for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_vsync | input | 1 | Vertical-sync event pulse |
| evt_uf_gl0 | input | 1 | Graphic layer 0 underflow pulse |
| evt_uf_gl1 | input | 1 | Graphic layer 1 underflow pulse |
| evt_uf_vp | input | 1 | Video plane underflow pulse |
| irq_out | output | 1 | Combined interrupt request |

## Verification
Directed sequences try each clear path on its own. One write clears a single underflow flag, so the test shows which flag a given bit position reaches. A write with bit 0 set and bit 11 clear checks that the vsync flag is read-only at bit 0. A write to the reserved bits only checks that those bits reach no flag at all. Further patterns place an event pulse and a clear of the same flag in one cycle (set must win), walk the enable bits against the flags so that the interrupt output shows which sources it combines, and access unmapped offsets to check that they neither read nor write. A long stretch of constrained random traffic then mixes events, reads and writes at mapped and unmapped offsets, and compares every cycle against a model kept in the bench.

// File: rtl/mixirq_pkg.sv
package mixirq_pkg;

    // number of interrupt sources handled by the block
    localparam int NSRC = 4;

    // internal source indices
    localparam int SRC_VSYNC = 0;
    localparam int SRC_GL0   = 1;
    localparam int SRC_GL1   = 2;
    localparam int SRC_VP    = 3;

    // write-only vsync clear position in the status word
    localparam int VSYNC_CLR_BIT = 11;

    typedef logic [NSRC-1:0] src_vec_t;

    // bit position of each source in both the status and the enable word
    function automatic int src_bit(input int src);
        case (src)
            SRC_VSYNC: src_bit = 0;
            SRC_GL0:   src_bit = 8;
            SRC_GL1:   src_bit = 9;
            default:   src_bit = 10;
        endcase
    endfunction

    // mask of the bits that software can see in the status or enable word
    function automatic logic [31:0] live_mask();
        live_mask = '0;
        for (int s = 0; s < NSRC; s++) begin
            live_mask[src_bit(s)] = 1'b1;
        end
    endfunction

endpackage

// File: rtl/mixirq_flag_bank.sv
module mixirq_flag_bank
    import mixirq_pkg::*;
#(
    parameter int NUM_SRC = NSRC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] flag_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] flag;
    } bank_state_t;

    bank_state_t st_d, st_q;

    // a hardware set always beats a software clear in the same cycle
    always_comb begin
        st_d = st_q;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (set_i[s]) begin
                st_d.flag[s] = 1'b1;
            end else if (clr_i[s]) begin
                st_d.flag[s] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
            assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
                set_i[g] |=> flag_o[g]);
            assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i[g] && !set_i[g]) |=> !flag_o[g]);
            assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (!clr_i[g] && !set_i[g]) |=> $stable(flag_o[g]));
        end
    endgenerate

endmodule

// File: rtl/mixirq_regif.sv
module mixirq_regif
    import mixirq_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int NUM_SRC  = NSRC,
    parameter int STAT_OFS = 'h0C,
    parameter int EN_OFS   = 'h10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic               bus_re,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] flag_i,
    output logic [NUM_SRC-1:0] clr_o,
    output logic [NUM_SRC-1:0] en_o
);

    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
    localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(EN_OFS);
    localparam logic [DATA_W-1:0] RSVD_M = ~DATA_W'(live_mask());

    typedef struct packed {
        logic [NUM_SRC-1:0] en;
        logic [DATA_W-1:0]  rdata;
    } regif_state_t;

    regif_state_t st_d, st_q;
    logic         stat_hit, en_hit;
    logic [NUM_SRC-1:0] clr_d;

    assign stat_hit = (bus_addr == STAT_A);
    assign en_hit   = (bus_addr == EN_A);

    // clear strobes toward the flag bank
    always_comb begin
        clr_d = '0;
        if (bus_we && stat_hit) begin
            for (int s = 0; s < NUM_SRC; s++) begin
                if (s == SRC_VSYNC) begin
                    clr_d[s] = bus_wdata[VSYNC_CLR_BIT];
                end else begin
                    clr_d[s] = bus_wdata[src_bit(s)];
                end
            end
        end
    end

    // enable register and registered read data
    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        if (bus_we && en_hit) begin
            for (int s = 0; s < NUM_SRC; s++) begin
                st_d.en[s] = bus_wdata[src_bit(s)];
            end
        end
        if (bus_re) begin
            if (stat_hit) begin
                for (int s = 0; s < NUM_SRC; s++) begin
                    st_d.rdata[src_bit(s)] = flag_i[s];
                end
            end else if (en_hit) begin
                for (int s = 0; s < NUM_SRC; s++) begin
                    st_d.rdata[src_bit(s)] = st_q.en[s];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign clr_o     = clr_d;
    assign en_o      = st_q.en;
    assign bus_rdata = st_q.rdata;

    assert_vsync_ro_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && stat_hit && !bus_wdata[VSYNC_CLR_BIT]) |-> !clr_o[SRC_VSYNC]);
    assert_rsvd_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & RSVD_M) == '0);
    assert_noread_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> (bus_rdata == '0));
    assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && !stat_hit && !en_hit) |=> (bus_rdata == '0));
    assert_en_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && en_hit) |=> $stable(en_o));

endmodule

// File: rtl/mixirq_combine.sv
module mixirq_combine
    import mixirq_pkg::*;
#(
    parameter int NUM_SRC = NSRC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] flag_i,
    input  logic [NUM_SRC-1:0] en_i,
    output logic               irq_o
);

    logic [NUM_SRC-1:0] live;

    always_comb begin
        live = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            live[s] = flag_i[s] & en_i[s];
        end
    end

    assign irq_o = |live;

    assert_irq_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i == '0) |-> !irq_o);
    assert_irq_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (flag_i != '0));

endmodule

// File: rtl/mixirq_status_top.sv
module mixirq_status_top
    import mixirq_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int STAT_OFS = 'h0C,
    parameter int EN_OFS   = 'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              evt_vsync,
    input  logic              evt_uf_gl0,
    input  logic              evt_uf_gl1,
    input  logic              evt_uf_vp,
    output logic              irq_out
);

    src_vec_t evt_vec, flag_vec, clr_vec, en_vec;

    always_comb begin
        evt_vec            = '0;
        evt_vec[SRC_VSYNC] = evt_vsync;
        evt_vec[SRC_GL0]   = evt_uf_gl0;
        evt_vec[SRC_GL1]   = evt_uf_gl1;
        evt_vec[SRC_VP]    = evt_uf_vp;
    end

    mixirq_flag_bank #(.NUM_SRC(NSRC)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (evt_vec),
        .clr_i  (clr_vec),
        .flag_o (flag_vec)
    );

    mixirq_regif #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .NUM_SRC  (NSRC),
        .STAT_OFS (STAT_OFS),
        .EN_OFS   (EN_OFS)
    ) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .flag_i    (flag_vec),
        .clr_o     (clr_vec),
        .en_o      (en_vec)
    );

    mixirq_combine #(.NUM_SRC(NSRC)) u_combine (
        .clk    (clk),
        .rst_n  (rst_n),
        .flag_i (flag_vec),
        .en_i   (en_vec),
        .irq_o  (irq_out)
    );

endmodule

// File: tb/test_mixirq_status_top.sv
module test_mixirq_status_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        evt_vsync = 1'b0, evt_uf_gl0 = 1'b0, evt_uf_gl1 = 1'b0, evt_uf_vp = 1'b0;
    logic        irq_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // model: [0] vsync, [1] gl0, [2] gl1, [3] vp
    logic [3:0] m_flag = '0;
    logic [3:0] m_en   = '0;

    always #5 clk = ~clk;

    mixirq_status_top i_mixirq_status_top (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_vsync(evt_vsync), .evt_uf_gl0(evt_uf_gl0), .evt_uf_gl1(evt_uf_gl1),
        .evt_uf_vp(evt_uf_vp), .irq_out(irq_out)
    );

    function automatic logic [31:0] pack(input logic [3:0] v);
        pack = '0;
        pack[0]  = v[0];
        pack[8]  = v[1];
        pack[9]  = v[2];
        pack[10] = v[3];
    endfunction

    function automatic logic [3:0] unpack(input logic [31:0] w);
        unpack = {w[10], w[9], w[8], w[0]};
    endfunction

    function automatic logic [31:0] model_read(input logic [7:0] a);
        if (a == 8'h0C)      model_read = pack(m_flag);
        else if (a == 8'h10) model_read = pack(m_en);
        else                 model_read = '0;
    endfunction

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one bus/event cycle; checks read data and irq after the edge
    task automatic step(input logic [3:0] ev, input logic we, input logic re,
                        input logic [7:0] a, input logic [31:0] wd, input string tag);
        logic [31:0] exp_rd;
        logic [3:0]  clr;
        @(negedge clk);
        {evt_uf_vp, evt_uf_gl1, evt_uf_gl0, evt_vsync} = ev;
        bus_we = we; bus_re = re; bus_addr = a; bus_wdata = wd;
        exp_rd = re ? model_read(a) : 32'h0;
        clr = '0;
        if (we && a == 8'h0C) clr = {wd[10], wd[9], wd[8], wd[11]};
        @(posedge clk);
        m_flag = ev | (m_flag & ~clr);
        if (we && a == 8'h10) m_en = unpack(wd);
        #1;
        check_eq({tag, " rdata R11"}, bus_rdata, exp_rd);
        check_eq({tag, " irq R9"}, {31'b0, irq_out}, {31'b0, |(m_flag & m_en)});
        {evt_uf_vp, evt_uf_gl1, evt_uf_gl0, evt_vsync} = '0;
        bus_we = 0; bus_re = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        check_eq("R1 rdata", bus_rdata, 32'h0);
        check_eq("R1 irq", {31'b0, irq_out}, 32'h0);
        step(4'b0000, 0, 1, 8'h0C, 0, "R1 status");
        step(4'b0000, 0, 1, 8'h10, 0, "R1 enable");

        // R2: vsync event, then read
        step(4'b0001, 0, 0, 8'h00, 0, "R2 set");
        step(4'b0000, 0, 1, 8'h0C, 0, "R2 read");
        // R4: write bit 0 without bit 11
        step(4'b0000, 1, 0, 8'h0C, 32'hFFFF_F7FF, "R4 write");
        step(4'b0000, 0, 1, 8'h0C, 0, "R4 read");
        check_eq("R4 vsync kept", bus_rdata, 32'h1);
        // R5: bit 11 clears vsync and reads 0
        step(4'b0000, 1, 0, 8'h0C, 32'h0000_0800, "R5 clear");
        step(4'b0000, 0, 1, 8'h0C, 0, "R5 read");
        check_eq("R5 cleared", bus_rdata, 32'h0);
        // R3: set all underflows, clear gl1 only
        step(4'b1110, 0, 0, 8'h00, 0, "R3 set");
        step(4'b0000, 1, 0, 8'h0C, 32'h0000_0200, "R3 clear gl1");
        step(4'b0000, 0, 1, 8'h0C, 0, "R3 read");
        check_eq("R3 only gl1 cleared", bus_rdata, 32'h0000_0500);
        // R6: reserved bits written, nothing changes
        step(4'b0000, 1, 0, 8'h0C, 32'hFFFF_F0FE, "R6 write");
        step(4'b0000, 0, 1, 8'h0C, 0, "R6 read");
        check_eq("R6 flags kept", bus_rdata, 32'h0000_0500);
        // R7: set and clear in the same cycle
        step(4'b1001, 1, 0, 8'h0C, 32'h0000_0C00, "R7 collide");
        step(4'b0000, 0, 1, 8'h0C, 0, "R7 read");
        check_eq("R7 set wins", bus_rdata, 32'h0000_0501);
        // R8: enable register
        step(4'b0000, 1, 0, 8'h10, 32'hFFFF_FFFF, "R8 write");
        step(4'b0000, 0, 1, 8'h10, 0, "R8 read");
        check_eq("R8 enable bits", bus_rdata, 32'h0000_0701);
        // R9: clear all, irq drops; enable-only-gl0 paths
        step(4'b0000, 1, 0, 8'h0C, 32'h0000_0F00, "R9 clear all");
        check_eq("R9 irq low", {31'b0, irq_out}, 32'h0);
        step(4'b0000, 1, 0, 8'h10, 32'h0000_0100, "R9 en gl0");
        step(4'b0100, 0, 0, 8'h00, 0, "R9 gl1 masked");
        check_eq("R9 masked source", {31'b0, irq_out}, 32'h0);
        step(4'b0010, 0, 0, 8'h00, 0, "R9 gl0 fires");
        check_eq("R9 irq high", {31'b0, irq_out}, 32'h1);
        step(4'b0000, 1, 0, 8'h10, 32'h0, "R9 disable");
        step(4'b0001, 0, 0, 8'h00, 0, "R9 stale vsync");
        step(4'b0000, 1, 0, 8'h0C, 32'h0000_0800, "R9 vsync clear");
        step(4'b0000, 1, 0, 8'h10, 32'h0000_0001, "R9 vsync enable");
        check_eq("R9 no stale irq", {31'b0, irq_out}, 32'h0);
        // R10: unmapped offsets
        step(4'b0000, 1, 0, 8'h04, 32'hFFFF_FFFF, "R10 write");
        step(4'b0000, 0, 1, 8'h04, 0, "R10 read 04");
        step(4'b0000, 0, 1, 8'h14, 0, "R10 read 14");
        step(4'b0000, 0, 1, 8'h0C, 0, "R10 status kept");
        step(4'b0000, 0, 1, 8'h10, 0, "R10 enable kept");
        check_eq("R10 enable unchanged", bus_rdata, 32'h1);
        // R11: no read gives zero
        step(4'b0000, 0, 0, 8'h0C, 0, "R11 idle");

        // constrained random traffic
        for (int i = 0; i < 800; i++) begin
            logic [3:0]  ev;
            logic [7:0]  a;
            logic [31:0] wd;
            logic        we, re;
            int          sel;
            ev  = (($urandom % 4) == 0) ? 4'($urandom) : 4'b0;
            sel = $urandom % 8;
            a   = (sel < 4) ? 8'h0C : (sel < 6) ? 8'h10 : (sel == 6) ? 8'h08 : 8'h14;
            we  = ($urandom % 3) == 0;
            re  = ($urandom % 2) == 0;
            wd  = $urandom;
            step(ev, we, re, a, wd, "random R2 R3 R5");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule